// File: doc/BRIEF.md
# Masked Message Match and Receive Interrupt Unit

This block follows an infrared message decoder. On every completed 64-bit message it compares the received bits with a programmable reference value. Only the bit positions selected by a programmable mask take part in the compare. A positive compare raises a dedicated match event. The block also collects three other receive events: plain message valid, message valid from a second decoder, and an input edge strobe. It keeps each of the four events as a pending bit.

Software programs the reference and mask as 32-bit halves through a simple write port. The same port writes an enable word and a clear word, and both use one shared bit layout. A single interrupt line is raised while any enabled source is pending. To wake the system only on one specific code, software enables only the match source. Plain valid events then stay pending but never reach the line.

Top module: `rx_match_irq`

## Requirements
- R1: The reference and the mask are each written as two 32-bit halves. Address 0 writes reference bits 31:0, address 1 writes reference bits 63:32, address 2 writes mask bits 31:0 and address 3 writes mask bits 63:32. Writing one half leaves the other half unchanged.
- R2: On a cycle with `msg_vld` high, the match pending bit (bit 2) is set on the next clock edge when `msg_data` equals the reference in every position where the mask bit is 1.
- R3: While the whole mask is zero, no match event is ever raised.
- R4: The pending bits use this layout: bit 0 is message valid, bit 1 is second-decoder valid, bit 2 is match and bit 3 is edge. Each bit is set one cycle after its strobe, whether or not the source is enabled.
- R5: Writing address 4 loads the enable word from `wr_data[3:0]`. `irq_o` is high exactly when some pending bit has its enable bit set.
- R6: Writing address 5 clears every pending bit whose `wr_data` bit is 1, with effect on the next edge. Pending bits written as 0 are unchanged.
- R7: When a clear and a new event for the same source fall in the same cycle, the pending bit ends up set.
- R8: A match is evaluated only in a cycle with `msg_vld` high, using the data present in that cycle. A change of `msg_data` without the strobe has no effect.
- R9: After reset, all pending bits, enables, reference bits and mask bits are zero, and `irq_o` is low.
- R10: With only the match source enabled, `irq_o` rises only for messages that pass the filter.
- R11: A filter write in the same cycle as a message does not affect that message. The message is compared with the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_vld | input | 1 | Primary decoder message-complete strobe |
| msg_data | input | 64 | Message bits captured with `msg_vld` |
| msg2_vld | input | 1 | Second decoder message-complete strobe |
| edge_stb | input | 1 | Input edge-detect strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0-3 filter halves, 4 enable, 5 clear) |
| wr_data | input | 32 | Register write data |
| pend_o | output | 4 | Pending status readback |
| irq_o | output | 1 | Interrupt line |

## Verification
The compare is tried with several kinds of message. One matches only in the masked bits. One differs by one bit in the masked low byte. One differs only in the masked upper half, and one is sent with an all-zero mask. Between them they separate a compare that uses the whole word, a compare that ignores one half, and a compare that treats a zero mask as always passing. A data change without a strobe, and a filter write in the same cycle as a message, show whether the compare is sampled at the right moment and against the right register contents. Clear words that collide with events, and clear words that name only some sources, separate the event-wins rule from a clear that wipes too much.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int N_SRC = 4;

  typedef enum int {
    SRC_VALID  = 0,
    SRC_VALID2 = 1,
    SRC_MATCH  = 2,
    SRC_EDGE   = 3
  } src_e;
endpackage

// File: rtl/rxm_cfg_regs.sv
module rxm_cfg_regs #(
  parameter int MSG_W  = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 3,
  parameter int NSRC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [MSG_W-1:0]  filt_data,
  output logic [MSG_W-1:0]  filt_mask,
  output logic [NSRC-1:0]   irq_en,
  output logic [NSRC-1:0]   clr_stb
);
  localparam int NUM_HALF = MSG_W / REG_W;
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(2 * NUM_HALF);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(2 * NUM_HALF + 1);

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(h);
    localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(NUM_HALF + h);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        filt_data[h*REG_W +: REG_W] <= '0;
      end else if (wr_en && wr_addr == A_DAT) begin
        filt_data[h*REG_W +: REG_W] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        filt_mask[h*REG_W +: REG_W] <= '0;
      end else if (wr_en && wr_addr == A_MSK) begin
        filt_mask[h*REG_W +: REG_W] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= '0;
    end else if (wr_en && wr_addr == A_EN) begin
      irq_en <= wr_data[NSRC-1:0];
    end
  end

  always_comb begin
    clr_stb = '0;
    if (wr_en && wr_addr == A_CLR) begin
      clr_stb = wr_data[NSRC-1:0];
    end
  end
endmodule

// File: rtl/rxm_match.sv
module rxm_match #(
  parameter int MSG_W = 64
) (
  input  logic             msg_vld,
  input  logic [MSG_W-1:0] msg_data,
  input  logic [MSG_W-1:0] filt_data,
  input  logic [MSG_W-1:0] filt_mask,
  output logic             hit
);
  function automatic logic masked_equal(input logic [MSG_W-1:0] rx,
                                        input logic [MSG_W-1:0] refv,
                                        input logic [MSG_W-1:0] sel);
    logic [MSG_W-1:0] diff;
    diff = (rx ^ refv) & sel;
    return (|sel) && (diff == '0);
  endfunction

  assign hit = msg_vld && masked_equal(msg_data, filt_data, filt_mask);
endmodule

// File: rtl/rxm_pending.sv
module rxm_pending #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] pend,
  output logic            irq
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[s] <= 1'b0;
      end else if (evt[s]) begin
        pend[s] <= 1'b1;
      end else if (clr[s]) begin
        pend[s] <= 1'b0;
      end
    end
  end

  assign irq = |(pend & en);
endmodule

// File: rtl/rx_match_irq.sv
module rx_match_irq #(
  parameter int MSG_W  = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_vld,
  input  logic [MSG_W-1:0]  msg_data,
  input  logic              msg2_vld,
  input  logic              edge_stb,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [rxm_pkg::N_SRC-1:0] pend_o,
  output logic              irq_o
);
  import rxm_pkg::*;

  logic [MSG_W-1:0] filt_data;
  logic [MSG_W-1:0] filt_mask;
  logic [N_SRC-1:0] irq_en;
  logic [N_SRC-1:0] clr_stb;
  logic [N_SRC-1:0] evt;
  logic             hit_evt;

  rxm_cfg_regs #(
    .MSG_W(MSG_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .NSRC(N_SRC)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .filt_data(filt_data), .filt_mask(filt_mask),
    .irq_en(irq_en), .clr_stb(clr_stb)
  );

  rxm_match #(.MSG_W(MSG_W)) u_match (
    .msg_vld(msg_vld), .msg_data(msg_data), .filt_data(filt_data),
    .filt_mask(filt_mask), .hit(hit_evt)
  );

  always_comb begin
    evt             = '0;
    evt[SRC_VALID]  = msg_vld;
    evt[SRC_VALID2] = msg2_vld;
    evt[SRC_MATCH]  = hit_evt;
    evt[SRC_EDGE]   = edge_stb;
  end

  rxm_pending #(.NSRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr_stb), .en(irq_en),
    .pend(pend_o), .irq(irq_o)
  );
endmodule

// File: rtl/rxm_checker.sv
module rxm_checker #(
  parameter int MSG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_vld,
  input logic             msg2_vld,
  input logic             edge_stb,
  input logic [MSG_W-1:0] filt_mask,
  input logic [3:0]       clr_stb,
  input logic             hit_evt,
  input logic [3:0]       pend_o,
  input logic             irq_o
);
  a_r3_zero_mask_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_mask == '0) |-> !hit_evt);

  a_r8_hit_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_vld |-> !hit_evt);

  a_r4_valid_sets: assert property (@(posedge clk) disable iff (!rst_n)
    msg_vld |=> pend_o[0]);

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (msg2_vld && clr_stb[1]) |=> pend_o[1]);

  a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |=> pend_o[3]);

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb[3] && !edge_stb) |=> !pend_o[3]);

  a_r5_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_o != 4'b0));

  a_r2_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> pend_o[2]);
endmodule

bind rx_match_irq rxm_checker #(.MSG_W(MSG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_vld(msg_vld), .msg2_vld(msg2_vld),
  .edge_stb(edge_stb), .filt_mask(filt_mask), .clr_stb(clr_stb),
  .hit_evt(hit_evt), .pend_o(pend_o), .irq_o(irq_o)
);

// File: tb/test_rx_match_irq.sv
`timescale 1ns/1ps
module test_rx_match_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_vld = 1'b0;
  logic [63:0] msg_data = '0;
  logic        msg2_vld = 1'b0;
  logic        edge_stb = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  pend_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [63:0] m_ref, m_mask;
  logic [3:0]  m_pend, m_en;

  always #5 clk = ~clk;

  rx_match_irq i_rx_match_irq (
    .clk(clk), .rst_n(rst_n), .msg_vld(msg_vld), .msg_data(msg_data),
    .msg2_vld(msg2_vld), .edge_stb(edge_stb), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pend_o(pend_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: updated at each edge from the values driven for that cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ref = '0; m_mask = '0; m_pend = '0; m_en = '0;
    end else begin
      logic hit;
      logic [3:0] clr;
      logic [3:0] ev;
      hit = msg_vld && (m_mask != 0);
      for (int b = 0; b < 64; b++)
        if (m_mask[b] && (msg_data[b] != m_ref[b])) hit = 0;
      clr = (wr_en && wr_addr == 3'd5) ? wr_data[3:0] : 4'h0;
      ev  = {edge_stb, hit, msg2_vld, msg_vld};
      m_pend = (m_pend & ~clr) | ev;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_ref[31:0]   = wr_data;
          3'd1: m_ref[63:32]  = wr_data;
          3'd2: m_mask[31:0]  = wr_data;
          3'd3: m_mask[63:32] = wr_data;
          3'd4: m_en          = wr_data[3:0];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the reference, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 cycle pending", {60'b0, pend_o}, {60'b0, m_pend});
      check("R5 cycle irq", {63'b0, irq_o}, {63'b0, |(m_pend & m_en)});
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
    msg_vld = 0; msg2_vld = 0; edge_stb = 0; wr_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
  endtask

  task automatic send(input logic [63:0] d);
    msg_vld = 1; msg_data = d;
    step();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1;
    step();
    check("R9 reset pending", {60'b0, pend_o}, 64'h0);
    check("R9 reset irq", {63'b0, irq_o}, 64'h0);

    // zero mask: valid pends, match never does; not enabled so no irq
    send(64'h0);
    check("R3 zero mask no match", {63'b0, pend_o[2]}, 64'h0);
    check("R4 valid pends while disabled", {63'b0, pend_o[0]}, 64'h1);
    check("R5 disabled no irq", {63'b0, irq_o}, 64'h0);

    // program the filter halves
    wr(3'd0, 32'h1234_5678);
    wr(3'd1, 32'hDEAD_BEEF);
    wr(3'd2, 32'h0000_00FF);
    wr(3'd3, 32'hFFFF_0000);
    wr(3'd5, 32'hF);
    check("R6 clear all", {60'b0, pend_o}, 64'h0);

    wr(3'd4, 32'h4);  // only the match source
    send(64'hDEAD_0000_9999_9978);
    check("R2 masked match pends", {63'b0, pend_o[2]}, 64'h1);
    check("R10 match raises irq", {63'b0, irq_o}, 64'h1);
    wr(3'd5, 32'h5);
    check("R10 cleared irq low", {63'b0, irq_o}, 64'h0);

    send(64'hDEAD_0000_9999_9979);
    check("R2 low byte mismatch", {63'b0, pend_o[2]}, 64'h0);
    check("R10 valid alone no irq", {63'b0, irq_o}, 64'h0);

    send(64'hDEAE_0000_0000_0078);
    check("R1 upper half compared", {63'b0, pend_o[2]}, 64'h0);

    // data change without strobe
    msg_data = 64'hDEAD_0000_0000_0078;
    step(); step();
    check("R8 no strobe no match", {63'b0, pend_o[2]}, 64'h0);

    // clear colliding with second-decoder event
    msg2_vld = 1; wr_en = 1; wr_addr = 3'd5; wr_data = 32'h2;
    step();
    check("R7 event beats clear", {63'b0, pend_o[1]}, 64'h1);

    edge_stb = 1;
    step();
    wr(3'd4, 32'h8);
    check("R5 edge enabled irq", {63'b0, irq_o}, 64'h1);
    wr(3'd5, 32'h1);
    check("R6 partial clear keeps edge", {63'b0, pend_o[3]}, 64'h1);
    check("R6 partial clear drops valid", {63'b0, pend_o[0]}, 64'h0);

    // filter write in same cycle as a non-matching message
    wr(3'd5, 32'hF);
    msg_vld = 1; msg_data = 64'hDEAD_0000_0000_0055;
    wr_en = 1; wr_addr = 3'd2; wr_data = 32'h0;
    step();
    check("R11 old mask used", {63'b0, pend_o[2]}, 64'h0);
    send(64'hDEAD_0000_0000_0055);
    check("R11 new mask used next", {63'b0, pend_o[2]}, 64'h1);
    check("R1 upper mask half kept", {63'b0, pend_o[2]}, 64'h1);

    wr(3'd4, 32'h0);
    wr(3'd5, 32'hF);
    check("R5 all disabled irq low", {63'b0, irq_o}, 64'h0);
    step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule